// File: doc/BRIEF.md
# Static RAM Write-Cycle Timing Monitor

This block watches the control and address pins of an asynchronous static RAM and checks each write against minimum timing limits. It runs on a fast sampling clock, and every quantity it measures is a count of sample-clock cycles. The pins are two chip enables, an active-low enable (`ce1_n`) and an active-high enable (`ce2`), an active-low write enable (`we_n`), and the address bus. A write exists only while all three controls are active together. It starts at whichever control becomes active last and ends at whichever control becomes inactive first.

For each write the monitor measures four values: the width of the write window, the time from chip enable to the end of the write, the address setup before the start, and the recovery from the end to the next address change. Each value is compared against a parameter minimum. The recovery limit depends on which control ended the write. The monitor also predicts whether the memory's data outputs stay high-impedance at the leading edge and at the trailing edge of the window. It reports a failure as a one-cycle pulse that carries a 3-bit code.

The inputs are assumed to be already synchronous to the sampling clock. The block does not model the memory array or any analog timing.

Top module: `sram_write_mon`

## Requirements
- R1: `wr_start` pulses for the sample in which `ce1_n`=0, `ce2`=1 and `we_n`=0 first hold together. This is the sample of the last of the three activating edges.
- R2: `wr_end` pulses for the first sample after a start in which any of the three controls is inactive. `wr_start` and `wr_end` are never high together.
- R3: At the end sample, the width is the number of samples during which the write was active. If the width is below `MIN_WP`, the violation code is 1.
- R4: At the end sample, the chip-enable-to-end time is the number of samples before the end sample during which both enables were active. If this time is below `MIN_CW`, the violation code is 2.
- R5: At the start sample, the address setup is the number of samples since the last address change. It is 0 if the address changes in the start sample itself. If the setup is below `MIN_AS`, the violation code is 3.
- R6: Recovery is the number of samples from the end sample to the first later address change. It is 0 if the address changes in the end sample. The limit is `MIN_WR2` with code 5 when `ce2` fell in the end sample and neither `ce1_n` nor `we_n` rose in that sample. In every other case the limit is `MIN_WR1` with code 4. If a new write starts before any address change, the pending recovery check is dropped.
- R7: `hiz_lead` pulses with `wr_start` when both enables were not already active in the previous sample. This happens when `ce1_n` falls in the same sample as `we_n` or later, or when `ce2` rises last.
- R8: `hiz_trail` pulses with `wr_end` when both enables are no longer active in the end sample. This happens when `ce1_n` rises no later than `we_n`, or when `ce2` ends the write.
- R9: All outputs are registered and appear one clock after the sample that caused them. `viol` is a one-cycle pulse. When several checks fail in one sample, the reported code is the lowest of the failing codes, in the order 1, 2, 3, 4, 5. `viol_code` is 0 when there is no violation.
- R10: Every measuring counter saturates at 2^`CNT_W`-1 and does not wrap.
- R11: A synchronous active-low reset clears all state. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Memory address |
| wr_start | output | 1 | Write window opened in the last sample |
| wr_end | output | 1 | Write window closed in the last sample |
| hiz_lead | output | 1 | Data outputs never left high-impedance before this write |
| hiz_trail | output | 1 | Data outputs stay high-impedance after this write |
| viol | output | 1 | One-cycle timing violation pulse |
| viol_code | output | 3 | Failing limit: 1 width, 2 enable-to-end, 3 setup, 4 recovery 1, 5 recovery 2 |

## Verification
The assertions check on every cycle that the start and end pulses never coincide and that two starts never occur back to back. They also check that the high-impedance flags only appear together with their window edge, that a violation pulse always carries a nonzero code, that saturated counters hold their value, and that reset leaves the outputs quiet. The actual measured numbers can only be shown by the bench's sweeps. Those sweeps vary the setup, width and recovery lengths, the order of the enables relative to the write enable, and which control ends the write, including simultaneous terminations. They also confirm the priority between width and enable-to-end failures and the saturation on a window longer than the counter range.

// File: rtl/sram_wmon_pkg.sv
// Shared types for the static RAM write-cycle monitor.
// Assumes nothing beyond a 3-bit violation code space.
package sram_wmon_pkg;
    typedef enum logic [2:0] {
        VC_NONE = 3'd0,
        VC_WP   = 3'd1,
        VC_CW   = 3'd2,
        VC_AS   = 3'd3,
        VC_WR1  = 3'd4,
        VC_WR2  = 3'd5
    } viol_code_e;
endpackage

// File: rtl/swm_sat_counter.sv
// Saturating up-counter with a load-to-one input.
// What it does: a load restarts the count at 1; otherwise inc adds one until all ones.
// Assumes: load has priority over inc; reset is synchronous and active low.
module swm_sat_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         inc_i,
    output logic [W-1:0] q_o
);
    localparam logic [W-1:0] MAX = '1;
    localparam logic [W-1:0] ONE = W'(1);

    // Count samples since the last load, holding at MAX.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= '0;
        else if (load_i)
            q_o <= ONE;
        else if (inc_i && (q_o != MAX))
            q_o <= q_o + ONE;
    end

    assert_counter_saturates_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o == MAX && inc_i && !load_i) |=> (q_o == MAX));
endmodule

// File: rtl/swm_window_tracker.sv
// Edge and window tracker for the monitored control pins.
// What it does: remembers last-sample pin values and derives the window start/end,
//   enable activation, address change, the ending cause and the high-impedance predictions.
// Assumes: pins are synchronous to clk.
module swm_window_tracker #(
    parameter int AW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce1_n,
    input  logic          ce2,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    output logic          wr_now_o,
    output logic          start_o,
    output logic          stop_o,
    output logic          ce_now_o,
    output logic          ce_rise_o,
    output logic          addr_chg_o,
    output logic          end_by_ce2_o,
    output logic          lead_hiz_o,
    output logic          trail_hiz_o
);
    logic          ce1_n_q, ce2_q, we_n_q, wr_q, ce_q;
    logic [AW-1:0] addr_q;
    logic          ce1_rose, we_rose, ce2_fell;

    // Remember the previous sample of every pin and of the derived window state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce1_n_q <= 1'b1;
            ce2_q   <= 1'b0;
            we_n_q  <= 1'b1;
            wr_q    <= 1'b0;
            ce_q    <= 1'b0;
            addr_q  <= '0;
        end else begin
            ce1_n_q <= ce1_n;
            ce2_q   <= ce2;
            we_n_q  <= we_n;
            wr_q    <= wr_now_o;
            ce_q    <= ce_now_o;
            addr_q  <= addr;
        end
    end

    // Derive window edges, the ending cause and the output-drive predictions.
    always_comb begin
        ce_now_o     = !ce1_n && ce2;
        wr_now_o     = ce_now_o && !we_n;
        start_o      = wr_now_o && !wr_q;
        stop_o       = !wr_now_o && wr_q;
        ce_rise_o    = ce_now_o && !ce_q;
        addr_chg_o   = (addr != addr_q);
        ce1_rose     = ce1_n && !ce1_n_q;
        we_rose      = we_n && !we_n_q;
        ce2_fell     = !ce2 && ce2_q;
        end_by_ce2_o = ce2_fell && !ce1_rose && !we_rose;
        lead_hiz_o   = start_o && !ce_q;
        trail_hiz_o  = stop_o && !ce_now_o;
    end

    assert_start_needs_all_active_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (!ce1_n && ce2 && !we_n));
    assert_edges_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_o, stop_o}));
endmodule

// File: rtl/swm_limit_judge.sv
// Compares measured sample counts against the minimum limits and picks one code.
// What it does: priority width > enable-to-end > setup > recovery 1 > recovery 2.
// Assumes: measured values are already zero-forced where an event coincides.
module swm_limit_judge
    import sram_wmon_pkg::*;
#(
    parameter int CNT_W   = 6,
    parameter int MIN_WP  = 4,
    parameter int MIN_CW  = 5,
    parameter int MIN_AS  = 2,
    parameter int MIN_WR1 = 2,
    parameter int MIN_WR2 = 3
) (
    input  logic             end_i,
    input  logic [CNT_W-1:0] wp_i,
    input  logic [CNT_W-1:0] cw_i,
    input  logic             start_i,
    input  logic [CNT_W-1:0] as_i,
    input  logic             rec_i,
    input  logic             rec_sel2_i,
    input  logic [CNT_W-1:0] rec_val_i,
    output viol_code_e       code_o
);
    localparam logic [CNT_W-1:0] LIM_WP  = CNT_W'(MIN_WP);
    localparam logic [CNT_W-1:0] LIM_CW  = CNT_W'(MIN_CW);
    localparam logic [CNT_W-1:0] LIM_AS  = CNT_W'(MIN_AS);
    localparam logic [CNT_W-1:0] LIM_WR1 = CNT_W'(MIN_WR1);
    localparam logic [CNT_W-1:0] LIM_WR2 = CNT_W'(MIN_WR2);

    // Pick the highest-priority failing limit for this sample.
    always_comb begin
        if (end_i && (wp_i < LIM_WP))
            code_o = VC_WP;
        else if (end_i && (cw_i < LIM_CW))
            code_o = VC_CW;
        else if (start_i && (as_i < LIM_AS))
            code_o = VC_AS;
        else if (rec_i && !rec_sel2_i && (rec_val_i < LIM_WR1))
            code_o = VC_WR1;
        else if (rec_i && rec_sel2_i && (rec_val_i < LIM_WR2))
            code_o = VC_WR2;
        else
            code_o = VC_NONE;
    end
endmodule

// File: rtl/sram_write_mon.sv
// Top of the static RAM write-cycle timing monitor.
// What it does: tracks the write window, measures width, enable-to-end, setup and
//   recovery in sample cycles, and reports registered flags and a violation code.
// Assumes: pins already synchronous to clk; synchronous active-low reset.
module sram_write_mon
    import sram_wmon_pkg::*;
#(
    parameter int AW      = 17,
    parameter int CNT_W   = 6,
    parameter int MIN_WP  = 4,
    parameter int MIN_CW  = 5,
    parameter int MIN_AS  = 2,
    parameter int MIN_WR1 = 2,
    parameter int MIN_WR2 = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce1_n,
    input  logic          ce2,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    output logic          wr_start,
    output logic          wr_end,
    output logic          hiz_lead,
    output logic          hiz_trail,
    output logic          viol,
    output logic [2:0]    viol_code
);
    localparam int NCNT = 4;
    localparam int IX_WP = 0, IX_CW = 1, IX_AS = 2, IX_RC = 3;

    logic wr_now, start, stop, ce_now, ce_rise, addr_chg, end_by_ce2, lead_hiz, trail_hiz;
    logic armed_q, sel2_q;
    logic [NCNT-1:0]  c_load, c_inc;
    logic [CNT_W-1:0] c_q [NCNT];
    logic [CNT_W-1:0] as_meas, rec_meas;
    logic             rec_chk, rec_sel2;
    viol_code_e       code_d, code_q;

    swm_window_tracker #(.AW(AW)) u_track (
        .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .we_n(we_n), .addr(addr),
        .wr_now_o(wr_now), .start_o(start), .stop_o(stop), .ce_now_o(ce_now),
        .ce_rise_o(ce_rise), .addr_chg_o(addr_chg), .end_by_ce2_o(end_by_ce2),
        .lead_hiz_o(lead_hiz), .trail_hiz_o(trail_hiz)
    );

    // Route each counter's restart and advance conditions.
    always_comb begin
        c_load[IX_WP] = start;    c_inc[IX_WP] = wr_now;
        c_load[IX_CW] = ce_rise;  c_inc[IX_CW] = ce_now;
        c_load[IX_AS] = addr_chg; c_inc[IX_AS] = 1'b1;
        c_load[IX_RC] = stop;     c_inc[IX_RC] = armed_q;
    end

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        swm_sat_counter #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .load_i(c_load[g]), .inc_i(c_inc[g]), .q_o(c_q[g])
        );
    end

    // Keep the pending recovery check and its limit selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            sel2_q  <= 1'b0;
        end else begin
            if (stop) begin
                armed_q <= !addr_chg;
                sel2_q  <= end_by_ce2;
            end else if (addr_chg || start) begin
                armed_q <= 1'b0;
            end
        end
    end

    // Form the measured values for events that coincide with a counter restart.
    always_comb begin
        as_meas  = addr_chg ? '0 : c_q[IX_AS];
        rec_chk  = addr_chg && (stop || armed_q);
        rec_meas = stop ? '0 : c_q[IX_RC];
        rec_sel2 = stop ? end_by_ce2 : sel2_q;
    end

    swm_limit_judge #(
        .CNT_W(CNT_W), .MIN_WP(MIN_WP), .MIN_CW(MIN_CW), .MIN_AS(MIN_AS),
        .MIN_WR1(MIN_WR1), .MIN_WR2(MIN_WR2)
    ) u_judge (
        .end_i(stop), .wp_i(c_q[IX_WP]), .cw_i(c_q[IX_CW]),
        .start_i(start), .as_i(as_meas),
        .rec_i(rec_chk), .rec_sel2_i(rec_sel2), .rec_val_i(rec_meas),
        .code_o(code_d)
    );

    // Register every reported output one clock after the sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_start  <= 1'b0;
            wr_end    <= 1'b0;
            hiz_lead  <= 1'b0;
            hiz_trail <= 1'b0;
            viol      <= 1'b0;
            code_q    <= VC_NONE;
        end else begin
            wr_start  <= start;
            wr_end    <= stop;
            hiz_lead  <= lead_hiz;
            hiz_trail <= trail_hiz;
            viol      <= (code_d != VC_NONE);
            code_q    <= code_d;
        end
    end

    assign viol_code = code_q;

    assert_start_not_repeated_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> !wr_start);
    assert_lead_with_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hiz_lead |-> wr_start);
    assert_trail_with_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hiz_trail |-> wr_end);
    assert_viol_has_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> (viol_code != 3'd0));
    assert_reset_quiet_R11: assert property (@(posedge clk)
        !rst_n |=> (!viol && !wr_start && !wr_end));
endmodule

// File: tb/sram_write_mon_tb.sv
// Sweep bench for the write-cycle monitor with a small counter width.
module sram_write_mon_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 17;
    localparam int CW = 4;
    localparam int P_WP = 3, P_CW = 4, P_AS = 3, P_WR1 = 2, P_WR2 = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce1_n = 1'b1, ce2 = 1'b0, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic wr_start, wr_end, hiz_lead, hiz_trail, viol;
    logic [2:0] viol_code;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_write_mon #(.AW(AW), .CNT_W(CW), .MIN_WP(P_WP), .MIN_CW(P_CW), .MIN_AS(P_AS),
                     .MIN_WR1(P_WR1), .MIN_WR2(P_WR2)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .we_n(we_n), .addr(addr),
        .wr_start(wr_start), .wr_end(wr_end), .hiz_lead(hiz_lead), .hiz_trail(hiz_trail),
        .viol(viol), .viol_code(viol_code)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one sample at the falling edge; outputs are read just after the next rising edge.
    task automatic smp(input logic c1, input logic c2, input logic w, input logic [AW-1:0] a);
        @(negedge clk);
        ce1_n = c1; ce2 = c2; we_n = w; addr = a;
        @(posedge clk);
        #1;
    endtask

    task automatic quiet(input string req);
        chk(!viol && !wr_start && !wr_end, req, {viol, wr_start, wr_end}, 0);
    endtask

    task automatic vchk(input int exp, input string req);
        chk((viol == (exp != 0)) && (viol_code == 3'(exp)), req, {viol, viol_code}, exp == 0 ? 0 : 8 + exp);
    endtask

    // One write: lead=0 enables before WE, lead=1 WE before enables; mode picks the ending control.
    task automatic do_write(input int lead, input int s, input int w, input int r, input int mode);
        logic [AW-1:0] a;
        logic e1, e2, ew;
        int cw, exp;
        a = addr + 1'b1;
        smp(1, 0, 1, a);
        quiet("R5 idle");
        for (int i = 1; i < s; i++) begin
            if (lead == 0) smp(0, 1, 1, a); else smp(1, 0, 0, a);
            quiet("R1 pre-start");
        end
        smp(0, 1, 0, a);
        chk(wr_start && !wr_end, "R1 start", wr_start, 1);
        chk(hiz_lead == lead[0], "R7 lead hiz", hiz_lead, lead);
        vchk((s < P_AS) ? 3 : 0, "R5 setup");
        for (int i = 1; i < w; i++) begin
            smp(0, 1, 0, a);
            quiet("R2 inside");
        end
        case (mode)
            0: begin e1 = 0; e2 = 1; ew = 1; end
            1: begin e1 = 1; e2 = 1; ew = 0; end
            2: begin e1 = 0; e2 = 0; ew = 0; end
            default: begin e1 = 0; e2 = 0; ew = 1; end
        endcase
        smp(e1, e2, ew, a);
        cw = (lead == 0) ? (s - 1 + w) : w;
        if (cw > 15) cw = 15;
        exp = (((w > 15) ? 15 : w) < P_WP) ? 1 : (cw < P_CW) ? 2 : 0;
        chk(wr_end && !wr_start, "R2 end", wr_end, 1);
        chk(hiz_trail == (mode != 0), "R8 trail hiz", hiz_trail, mode != 0);
        vchk(exp, "R3 R4 R9 R10 end checks");
        for (int i = 1; i < r; i++) begin
            smp(e1, e2, ew, a);
            quiet("R6 recovery wait");
        end
        smp(e1, e2, ew, a + 1'b1);
        if (mode == 2) exp = (r < P_WR2) ? 5 : 0;
        else exp = (r < P_WR1) ? 4 : 0;
        vchk(exp, "R6 recovery");
        smp(1, 0, 1, addr);
        smp(1, 0, 1, addr);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(!viol && !wr_start && !wr_end && !hiz_lead && !hiz_trail && viol_code == 0,
            "R11 reset state", viol_code, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (20) smp(1, 0, 1, addr);
        quiet("R11 idle after reset");
        for (int lead = 0; lead < 2; lead++)
            for (int s = 2; s <= 3; s++)
                for (int w = 1; w <= 6; w++)
                    for (int r = 1; r <= 4; r++)
                        for (int m = 0; m < 4; m++)
                            do_write(lead, s, w, r, m);
        // R10: a window longer than the counter range must not wrap into a width failure.
        do_write(1, 3, 17, 3, 0);
        do_write(0, 3, 20, 3, 2);
        // R11: reset in the middle of a write clears the pending state.
        smp(0, 1, 0, addr);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk(!viol && !wr_start && !wr_end, "R11 reset mid-write", viol, 0);
        @(negedge clk);
        ce1_n = 1; ce2 = 0; we_n = 1;
        rst_n = 1'b1;
        repeat (3) smp(1, 0, 1, addr);
        quiet("R11 quiet after mid-write reset");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule